// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block runs a disk-style channel's bus-master transfer from a list of memory regions. Software writes the address of a descriptor table, then writes the go bit. The walker reads each 8-byte entry through a one-dword memory read port. It decodes the region's start address, its byte length and an end-of-table marker from the entry. It then gives the region to a data mover as a single command and holds that command until the mover reports the region finished. The walker repeats this for each entry until it reaches the one with the end marker. It can also stop early if software drops the go bit.

The walker keeps a busy flag that software can read. The flag rises when a walk starts and falls on its own, but only after the mover has completed the last region. A separate interrupt status flag records that the attached device raised its interrupt line. That flag has no link to descriptor progress, and software clears it by writing a one to it.

The controller is one state machine. Its states are `ST_IDLE` (waiting for go), `ST_FETCH_LO` (reading the address dword), `ST_FETCH_HI` (reading the count/flag dword), `ST_MOVE` (region command outstanding) and `ST_STEP` (deciding what follows). Its transitions are:
- start: `ST_IDLE`→`ST_FETCH_LO` on a go write.
- lo_taken: `ST_FETCH_LO`→`ST_FETCH_HI` on memory acknowledge.
- hi_taken: `ST_FETCH_HI`→`ST_MOVE` on memory acknowledge.
- region_done: `ST_MOVE`→`ST_STEP` on mover done.
- advance: `ST_STEP`→`ST_FETCH_LO` when the entry was not the last one and go is still set.
- finish: `ST_STEP`→`ST_IDLE` when the entry was the last one or go was cleared.

Top module: `sgdma_walker`

## Requirements
- R1: After reset the block is idle. `active`, `irq_sts`, `run_en`, `mem_req` and `mv_req` are all 0.
- R2: A write to select 0 with data bit 0 set, made while idle, latches the table pointer from the base register and sets `active` in the same clock edge. The first memory read goes to that base address. A base write (select 1) drops data bits [1:0].
- R3: The region address sent on `mv_addr` equals bits [31:1] of the entry's first dword, with bit 0 forced to 0.
- R4: The region length sent on `mv_len` is twice the value in bits [15:1] of the entry's second dword. Bits [30:16] and bit 0 of that dword have no effect.
- R5: When bits [15:1] of the second dword are all zero, `mv_len` is 65536.
- R6: For each entry the walker reads the dword at the pointer and then the dword at pointer+4. The next entry's pointer is 8 above the current one.
- R7: Bit 31 of the second dword marks the last entry. `active` stays 1 until `mv_done` for that entry's region, and it is 0 two edges later. No further memory read follows.
- R8: Writing select 0 with bit 0 clear while a walk is running lets the current region finish. After that no new entry is fetched and `active` clears.
- R9: `irq_sts` becomes 1 on the edge after any cycle in which `dev_irq` is high, whatever the walker is doing.
- R10: Writing select 2 with bit 0 set clears `irq_sts`, unless `dev_irq` is high in that cycle, in which case setting wins. Writing select 2 with bit 0 clear leaves `irq_sts` unchanged.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. `mv_req` stays high with stable `mv_addr` and `mv_len` until `mv_done`.
- R12: A go write while `active` is 1 does not restart the walk. A base write while `active` is 1 does not affect the running walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 table base, 2 status clear |
| wr_data | input | 32 | Register write data |
| dev_irq | input | 1 | Device interrupt line |
| mem_req | output | 1 | Descriptor dword read request |
| mem_addr | output | 32 | Descriptor dword byte address |
| mem_ack | input | 1 | Read accepted; `mem_rdata` valid in this cycle |
| mem_rdata | input | 32 | Read data |
| mv_req | output | 1 | Region command to data mover |
| mv_addr | output | 32 | Region start address (even) |
| mv_len | output | 17 | Region byte count, 2 to 65536 |
| mv_done | input | 1 | Mover finished the current region |
| active | output | 1 | Walk in progress |
| run_en | output | 1 | Current value of the go bit |
| irq_sts | output | 1 | Sticky device interrupt status |

## Verification
The handshake assertions assume that the memory and mover sides raise `mem_ack` and `mv_done` only while the matching request is high, and that `mem_rdata` is valid in the acknowledge cycle. The bench's responders wait at the falling edge for a request and then wait a random 0 to 3 cycles, or a fixed longer delay in the stop tests. They then pulse the acknowledge for exactly one cycle. The bench supplies read data only for addresses inside its own table and counts any read outside it, or out of order, as an error. Tables are drawn from a fixed seed. Reserved bits are filled with random values, and zero counts are forced now and then.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_MOVE,
        ST_STEP
    } walk_st_e;

    // register selects
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_BASE = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    // descriptor geometry
    localparam int ENTRY_BYTES = 8;
    localparam int DWORD_BYTES = 4;
    localparam int LAST_BIT    = 31;

endpackage

// File: rtl/sgw_regs.sv
module sgw_regs
    import sgw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          dev_irq,
    output logic          go,
    output logic          run_q,
    output logic [AW-1:0] base_q,
    output logic          irq_sts
);

    logic ctrl_wr;
    logic base_wr;
    logic stat_wr;

    always_comb begin
        ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
        base_wr = wr_en && (wr_sel == SEL_BASE);
        stat_wr = wr_en && (wr_sel == SEL_STAT);
        go      = ctrl_wr && wr_data[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            base_q  <= '0;
            irq_sts <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                run_q <= wr_data[0];
            end
            if (base_wr) begin
                base_q <= {wr_data[AW-1:2], 2'b00};
            end
            if (dev_irq) begin
                irq_sts <= 1'b1;
            end else if (stat_wr && wr_data[0]) begin
                irq_sts <= 1'b0;
            end
        end
    end

    p_irq_set_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq |=> irq_sts);

    p_irq_clr_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wr_data[0] && !dev_irq) |=> !irq_sts);

    p_irq_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_irq && !(stat_wr && wr_data[0])) |=> (irq_sts == $past(irq_sts)));

endmodule

// File: rtl/sgw_decode.sv
module sgw_decode
    import sgw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic [31:0]   dw_lo,
    input  logic [31:0]   dw_hi,
    output logic [AW-1:0] reg_addr,
    output logic [CNT_W:0] reg_len,
    output logic          reg_last
);

    localparam int LEN_W = CNT_W + 1;

    logic [CNT_W-2:0] cnt_field;
    logic             unused_bits;

    always_comb begin
        cnt_field = dw_hi[CNT_W-1:1];
        reg_addr  = {dw_lo[AW-1:1], 1'b0};
        reg_last  = dw_hi[LAST_BIT];
        if (cnt_field == '0) begin
            reg_len = {1'b1, {CNT_W{1'b0}}};
        end else begin
            reg_len = LEN_W'({cnt_field, 1'b0});
        end
    end

    assign unused_bits = ^{dw_hi[LAST_BIT-1:CNT_W], dw_hi[0], dw_lo[0]};

endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
    import sgw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          run_q,
    input  logic [AW-1:0] base_q,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic [31:0]   dw_lo_q,
    output logic [31:0]   dw_hi_q,
    input  logic          reg_last,
    output logic          mv_req,
    input  logic          mv_done,
    output logic          active
);

    localparam logic [AW-1:0] STEP_BYTES = AW'(ENTRY_BYTES);
    localparam logic [AW-1:0] HI_OFFSET  = AW'(DWORD_BYTES);

    walk_st_e      state, state_nx;
    logic [AW-1:0] ptr;
    logic          finish;

    assign finish = reg_last || !run_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (go)      state_nx = ST_FETCH_LO;
            ST_FETCH_LO: if (mem_ack) state_nx = ST_FETCH_HI;
            ST_FETCH_HI: if (mem_ack) state_nx = ST_MOVE;
            ST_MOVE:     if (mv_done) state_nx = ST_STEP;
            ST_STEP:     state_nx = finish ? ST_IDLE : ST_FETCH_LO;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr     <= '0;
            dw_lo_q <= '0;
            dw_hi_q <= '0;
            active  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        ptr    <= base_q;
                        active <= 1'b1;
                    end
                end
                ST_FETCH_LO: if (mem_ack) dw_lo_q <= mem_rdata;
                ST_FETCH_HI: if (mem_ack) dw_hi_q <= mem_rdata;
                ST_MOVE: ;
                ST_STEP: begin
                    if (finish) begin
                        active <= 1'b0;
                    end else begin
                        ptr <= ptr + STEP_BYTES;
                    end
                end
                default: active <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = ptr;
        mv_req   = 1'b0;
        unique case (state)
            ST_FETCH_LO: mem_req = 1'b1;
            ST_FETCH_HI: begin
                mem_req  = 1'b1;
                mem_addr = ptr + HI_OFFSET;
            end
            ST_MOVE: mv_req = 1'b1;
            default: ;
        endcase
    end

    p_mem_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_mv_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_done) |=> mv_req);

    p_hi_follows_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && state == ST_FETCH_LO) |=>
            (mem_req && mem_addr == $past(mem_addr) + HI_OFFSET));

    p_last_ends_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && mv_done && reg_last) |=> ##1 (!active && !mem_req));

    p_busy_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || mv_req) |-> active);

endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
    import sgw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             dev_irq,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             mv_req,
    output logic [AW-1:0]    mv_addr,
    output logic [CNT_W:0]   mv_len,
    input  logic             mv_done,
    output logic             active,
    output logic             run_en,
    output logic             irq_sts
);

    logic          go;
    logic [AW-1:0] base_q;
    logic [31:0]   dw_lo_q;
    logic [31:0]   dw_hi_q;
    logic          reg_last;

    sgw_regs #(.AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .dev_irq (dev_irq),
        .go      (go),
        .run_q   (run_en),
        .base_q  (base_q),
        .irq_sts (irq_sts)
    );

    sgw_walker #(.AW(AW)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .run_q     (run_en),
        .base_q    (base_q),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .dw_lo_q   (dw_lo_q),
        .dw_hi_q   (dw_hi_q),
        .reg_last  (reg_last),
        .mv_req    (mv_req),
        .mv_done   (mv_done),
        .active    (active)
    );

    sgw_decode #(.AW(AW), .CNT_W(CNT_W)) u_dec (
        .dw_lo    (dw_lo_q),
        .dw_hi    (dw_hi_q),
        .reg_addr (mv_addr),
        .reg_len  (mv_len),
        .reg_last (reg_last)
    );

    p_region_stable_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_done) |=> ($stable(mv_addr) && $stable(mv_len)));

    p_region_even_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |-> (!mv_addr[0] && !mv_len[0]));

    p_len_nonzero_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |-> (mv_len != '0));

endmodule

// File: tb/sim_sgdma_walker.sv
`timescale 1ns/1ps
module sim_sgdma_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        dev_irq = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        mv_req;
    logic [31:0] mv_addr;
    logic [16:0] mv_len;
    logic        mv_done = 1'b0;
    logic        active;
    logic        run_en;
    logic        irq_sts;

    int vectors = 0;
    int fails = 0;

    logic [31:0] tbl [0:63];
    logic [31:0] tbl_base = 32'h0;
    int nfetch = 0;
    int fetch_err = 0;
    int nreg = 0;
    logic [31:0] log_addr [0:15];
    logic [16:0] log_len  [0:15];
    logic        log_act  [0:15];
    int mdly = 0;
    int vdly = 0;
    int mv_lat = -1;

    always #2 clk = ~clk;

    sgdma_walker u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .dev_irq(dev_irq), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len),
        .mv_done(mv_done), .active(active), .run_en(run_en),
        .irq_sts(irq_sts)
    );

    // memory responder
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (mdly == 0) begin
                if (mem_addr != tbl_base + 32'(nfetch * 4) || mem_addr < tbl_base
                    || mem_addr >= tbl_base + 32'd256) begin
                    fetch_err++;
                    mem_rdata = 32'hDEAD_BEEF;
                end else begin
                    mem_rdata = tbl[(mem_addr - tbl_base) >> 2];
                end
                nfetch++;
                mem_ack = 1'b1;
                mdly = int'($urandom % 4);
            end else begin
                mdly--;
            end
        end
    end

    // data mover responder
    always @(negedge clk) begin
        if (mv_done) begin
            mv_done = 1'b0;
        end else if (mv_req) begin
            if (vdly == 0) begin
                if (nreg < 16) begin
                    log_addr[nreg] = mv_addr;
                    log_len[nreg]  = mv_len;
                    log_act[nreg]  = active;
                end
                nreg++;
                mv_done = 1'b1;
                vdly = (mv_lat < 0) ? int'($urandom % 4) : mv_lat;
            end else begin
                vdly--;
            end
        end
    end

    function automatic logic [31:0] exp_addr(input logic [31:0] lo);
        return lo & 32'hFFFF_FFFE;
    endfunction

    function automatic logic [31:0] exp_len(input logic [31:0] hi);
        int c;
        c = int'(hi[15:1]);
        return (c == 0) ? 32'd65536 : 32'(c * 2);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            if (!active) break;
            @(negedge clk);
        end
    endtask

    task automatic begin_walk(input logic [31:0] base);
        nfetch = 0;
        fetch_err = 0;
        nreg = 0;
        tbl_base = base;
        reg_write(2'd1, base);
        reg_write(2'd0, 32'h1);
        check("R2 active after go", 32'(active), 32'd1);
    endtask

    task automatic verify_walk(input int n, input string tag);
        check({tag, " region count"}, 32'(nreg), 32'(n));
        check("R6 fetch count", 32'(nfetch), 32'(2 * n));
        check("R6 fetch order", 32'(fetch_err), 32'd0);
        for (int i = 0; i < n && i < 16; i++) begin
            check("R3 region addr", log_addr[i], exp_addr(tbl[2*i]));
            check("R4 R5 region len", 32'(log_len[i]), exp_len(tbl[2*i+1]));
            check("R7 active during region", 32'(log_act[i]), 32'd1);
        end
        check("R7 active cleared", 32'(active), 32'd0);
        repeat (6) @(negedge clk);
        check("R7 no read after end", 32'(nfetch), 32'(2 * n));
    endtask

    task automatic fill(input int n, input int last_at);
        for (int i = 0; i < n; i++) begin
            tbl[2*i]   = $urandom;
            tbl[2*i+1] = ($urandom & 32'h7FFF_FFFF) | ((i == last_at) ? 32'h8000_0000 : 32'h0);
            if ($urandom % 4 == 0) tbl[2*i+1] = tbl[2*i+1] & 32'hFFFF_0001;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) tbl[i] = 32'h0;
        repeat (3) @(negedge clk);
        check("R1 active reset", 32'(active), 32'd0);
        check("R1 irq reset", 32'(irq_sts), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle outputs", {28'd0, run_en, irq_sts, mem_req, mv_req}, 32'd0);

        // directed: odd addr, reserved bits set, zero count, last on third
        tbl[0] = 32'h1234_5679; tbl[1] = 32'h7FFF_0011;
        tbl[2] = 32'h0000_1001; tbl[3] = 32'h1234_0001;
        tbl[4] = 32'hABCD_0000; tbl[5] = 32'h8000_FFFF;
        tbl[6] = 32'h5555_5554; tbl[7] = 32'h8000_0100;
        begin_walk(32'h0000_4000);
        check("R2 first fetch base", 32'(nfetch) , 32'd0);
        wait_idle();
        verify_walk(3, "R7");
        check("R4 reserved ignored", 32'(log_len[0]), 32'h10);
        check("R5 zero count", 32'(log_len[1]), 32'd65536);
        check("R3 odd addr", log_addr[0], 32'h1234_5678);

        // base write drops low bits
        tbl[0] = 32'h0000_2000; tbl[1] = 32'h8000_0040;
        nfetch = 0; fetch_err = 0; nreg = 0; tbl_base = 32'h0000_6000;
        reg_write(2'd1, 32'h0000_6003);
        reg_write(2'd0, 32'h1);
        wait_idle();
        check("R2 base alignment", 32'(fetch_err), 32'd0);
        check("R2 single entry", 32'(nreg), 32'd1);

        // random tables
        for (int r = 0; r < 10; r++) begin
            int n;
            n = 1 + int'($urandom % 6);
            fill(n, n - 1);
            begin_walk(32'h0002_0000 + (($urandom % 64) << 2));
            wait_idle();
            verify_walk(n, "R7");
        end

        // stop mid-walk
        fill(4, 3);
        mv_lat = 8;
        vdly = 8;
        begin_walk(32'h0000_8000);
        while (!mv_req) @(negedge clk);
        reg_write(2'd0, 32'h0);
        wait_idle();
        check("R8 one region then stop", 32'(nreg), 32'd1);
        check("R8 active cleared", 32'(active), 32'd0);
        repeat (20) @(negedge clk);
        check("R8 no further fetch", 32'(nfetch), 32'd2);
        check("R8 run bit low", 32'(run_en), 32'd0);

        // go and base write while active
        mv_lat = 4;
        fill(3, 2);
        begin_walk(32'h0000_9000);
        while (!mv_req) @(negedge clk);
        reg_write(2'd1, 32'h0000_A000);
        reg_write(2'd0, 32'h1);
        wait_idle();
        verify_walk(3, "R12");
        mv_lat = -1;
        vdly = 0;

        // interrupt status
        dev_irq = 1'b1;
        @(negedge clk);
        dev_irq = 1'b0;
        @(negedge clk);
        check("R9 irq set", 32'(irq_sts), 32'd1);
        reg_write(2'd2, 32'h0);
        check("R10 write zero keeps", 32'(irq_sts), 32'd1);
        reg_write(2'd2, 32'h1);
        check("R10 w1c clears", 32'(irq_sts), 32'd0);
        dev_irq = 1'b1;
        reg_write(2'd2, 32'h1);
        check("R10 set wins", 32'(irq_sts), 32'd1);
        dev_irq = 1'b0;
        reg_write(2'd2, 32'h1);
        check("R10 cleared", 32'(irq_sts), 32'd0);

        // irq during a walk
        fill(2, 1);
        begin_walk(32'h0000_C000);
        dev_irq = 1'b1;
        @(negedge clk);
        dev_irq = 1'b0;
        wait_idle();
        verify_walk(2, "R9");
        check("R9 irq during walk", 32'(irq_sts), 32'd1);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule